// File: doc/BRIEF.md
# TLB Selective Invalidation Engine

This block keeps the tag side of a small fully associative translation buffer and carries out the invalidate command. Each entry has a valid flag, a global flag, an address-space identifier (ASID) and a virtual page number (VPN). A command brings a 5-bit operation code, an ASID operand, a VPN operand and a flag that marks user privilege. A legal command at kernel privilege walks the entries one per clock. It drops the valid flag of every entry that the operation code selects. It then pulses a completion strobe and a pipeline flush request, so that later fetches see the updated translations.

A command issued at user privilege raises a privilege exception and changes nothing. An operation code outside the defined set raises an illegal-operation error and changes nothing. A write port loads entries and a probe port reads back the valid flag of any entry. Both ports serve testing and bring-up.

Top module: `tlbinv_engine`

## Requirements
- R1: After reset, busy, done, flush_req, priv_exc and illegal_op are 0 and every entry's valid flag reads 0 on the probe port.
- R2: With busy low and no command accepted in the same cycle, wr_en stores wr_valid, wr_global, wr_asid and wr_vpn into entry wr_idx. The probe port returns the valid flag of entry probe_idx one cycle after the address is presented.
- R3: Operation codes 0 and 1 clear the valid flag of every entry.
- R4: Operation code 2 clears only the entries whose global flag is 1.
- R5: Operation code 3 clears only the entries whose global flag is 0.
- R6: Operation code 4 clears only the entries whose global flag is 0 and whose ASID equals cmd_asid.
- R7: Operation code 5 clears only the entries whose VPN equals cmd_vpn and whose ASID equals cmd_asid.
- R8: Operation code 6 clears only the entries whose VPN equals cmd_vpn and that either have ASID equal to cmd_asid or have the global flag set.
- R9: At kernel privilege, operation codes 7 to 31 pulse illegal_op for one cycle, in the cycle after acceptance. busy, done and flush_req stay 0 and no entry changes.
- R10: When cmd_user is 1, the command pulses priv_exc for one cycle, in the cycle after acceptance. This holds for any operation code and takes precedence over illegal_op. No entry changes.
- R11: A legal command keeps busy high for exactly ENTRIES cycles, starting the cycle after acceptance. done and flush_req then pulse together for one cycle, in the first cycle that busy is low.
- R12: While busy is high, new commands and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Invalidate command present |
| cmd_op | input | 5 | Operation code |
| cmd_asid | input | ASID_W | ASID operand |
| cmd_vpn | input | VPN_W | VPN operand |
| cmd_user | input | 1 | 1 = issued at user privilege |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_global | input | 1 | Global flag to store |
| wr_asid | input | ASID_W | ASID to store |
| wr_vpn | input | VPN_W | VPN to store |
| probe_idx | input | IDX_W | Entry index to probe |
| probe_valid | output | 1 | Valid flag of the probed entry (registered) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| flush_req | output | 1 | One-cycle flush request pulse |
| priv_exc | output | 1 | One-cycle privilege exception pulse |
| illegal_op | output | 1 | One-cycle illegal operation pulse |

## Verification
A command is accepted on a clock edge. priv_exc or illegal_op is due in the cycle right after that edge. busy is due in the same cycle and holds for ENTRIES cycles, and done with flush_req is due in the first cycle after busy falls. The bench drives and samples on falling edges, counts busy cycles one per cycle and checks the pulses exactly there. Probe reads are sampled one full cycle after the address is set. After each command the bench reads back every entry and compares it with a model of the selection rules.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [4:0] {
    INV_ALL_A      = 5'd0,
    INV_ALL_B      = 5'd1,
    INV_GLOBAL     = 5'd2,
    INV_LOCAL      = 5'd3,
    INV_SPACE      = 5'd4,
    INV_PAGE_SPACE = 5'd5,
    INV_PAGE_SHARE = 5'd6
  } inv_op_e;

  localparam int unsigned OP_W = 5;

  function automatic logic op_is_legal(input logic [OP_W-1:0] op);
    return op <= INV_PAGE_SHARE;
  endfunction

endpackage

// File: rtl/tlbinv_tag_ram.sv
module tlbinv_tag_ram #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ASID_W  = 10,
  parameter int unsigned VPN_W   = 19,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned TAG_W  = 1 + ASID_W + VPN_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic              wglobal,
  input  logic [ASID_W-1:0] wasid,
  input  logic [VPN_W-1:0]  wvpn,
  input  logic [IDX_W-1:0]  raddr,
  output logic              rglobal,
  output logic [ASID_W-1:0] rasid,
  output logic [VPN_W-1:0]  rvpn
);

  logic [TAG_W-1:0] mem [ENTRIES];
  logic [TAG_W-1:0] rdata_q;

  // Simple dual-port memory, synchronous read: maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= {wglobal, wasid, wvpn};
    end
    rdata_q <= mem[raddr];
  end

  assign rglobal = rdata_q[TAG_W-1];
  assign rasid   = rdata_q[TAG_W-2 -: ASID_W];
  assign rvpn    = rdata_q[VPN_W-1:0];

endmodule

// File: rtl/tlbinv_valid_bits.sv
module tlbinv_valid_bits #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_val,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic             cur_valid,
  input  logic [IDX_W-1:0] probe_idx,
  output logic             probe_q
);

  logic [ENTRIES-1:0] valid_q;

  // One flop per entry so any entry can be cleared in a single cycle.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
      end else if (set_en && set_idx == IDX_W'(g)) begin
        valid_q[g] <= set_val;
      end else if (clr_en && clr_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  assign cur_valid = valid_q[clr_idx];

  always_ff @(posedge clk) begin
    if (rst) probe_q <= 1'b0;
    else     probe_q <= valid_q[probe_idx];
  end

  // A flag may only fall after a walk clear or an explicit write.
  assert_clear_needs_cause_R12: assert property (@(posedge clk) disable iff (rst)
    (|($past(valid_q) & ~valid_q)) |-> ($past(clr_en) || $past(set_en)));

endmodule

// File: rtl/tlbinv_matcher.sv
module tlbinv_matcher
  import tlbinv_pkg::*;
#(
  parameter int unsigned ASID_W = 10,
  parameter int unsigned VPN_W  = 19
) (
  input  logic [OP_W-1:0]   op,
  input  logic              ent_valid,
  input  logic              ent_global,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic [VPN_W-1:0]  key_vpn,
  output logic              hit
);

  logic asid_eq;
  logic vpn_eq;
  logic sel;

  assign asid_eq = (ent_asid == key_asid);
  assign vpn_eq  = (ent_vpn == key_vpn);

  always_comb begin
    unique case (op)
      INV_ALL_A, INV_ALL_B: sel = 1'b1;
      INV_GLOBAL:           sel = ent_global;
      INV_LOCAL:            sel = !ent_global;
      INV_SPACE:            sel = !ent_global && asid_eq;
      INV_PAGE_SPACE:       sel = vpn_eq && asid_eq;
      INV_PAGE_SHARE:       sel = vpn_eq && (asid_eq || ent_global);
      default:              sel = 1'b0;
    endcase
  end

  assign hit = ent_valid && sel;

endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] raddr,
  output logic             done,
  output logic             flush_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ptr       <= '0;
      done      <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      done      <= 1'b0;
      flush_req <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          ptr  <= '0;
        end
      end else if (ptr == LAST) begin
        busy      <= 1'b0;
        ptr       <= '0;
        done      <= 1'b1;
        flush_req <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // Read one entry ahead: the memory output lines up with ptr.
  always_comb begin
    if (busy && ptr != LAST) raddr = ptr + 1'b1;
    else                     raddr = '0;
  end

  assert_start_begins_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && ptr == '0));
  assert_last_ends_walk_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && ptr == LAST) |=> (!busy && done && flush_req));
  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ASID_W  = 10,
  parameter int unsigned VPN_W   = 19,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [4:0]        cmd_op,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic              cmd_user,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_global,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic              probe_valid,
  output logic              busy,
  output logic              done,
  output logic              flush_req,
  output logic              priv_exc,
  output logic              illegal_op
);

  logic              accept, start, wr_ok;
  logic [OP_W-1:0]   op_q;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [IDX_W-1:0]  ptr, raddr;
  logic              t_global, cur_valid, hit;
  logic [ASID_W-1:0] t_asid;
  logic [VPN_W-1:0]  t_vpn;

  assign accept = cmd_valid && !busy;
  assign start  = accept && !cmd_user && op_is_legal(cmd_op);
  // Writes are held off during a walk and in the cycle a walk is accepted,
  // so the prefetched first tag cannot go stale.
  assign wr_ok  = wr_en && !busy && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_exc   <= 1'b0;
      illegal_op <= 1'b0;
      op_q       <= '0;
      asid_q     <= '0;
      vpn_q      <= '0;
    end else begin
      priv_exc   <= accept && cmd_user;
      illegal_op <= accept && !cmd_user && !op_is_legal(cmd_op);
      if (start) begin
        op_q   <= cmd_op;
        asid_q <= cmd_asid;
        vpn_q  <= cmd_vpn;
      end
    end
  end

  tlbinv_walker #(.ENTRIES(ENTRIES)) u_walker (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .ptr(ptr),
    .raddr(raddr), .done(done), .flush_req(flush_req)
  );

  tlbinv_tag_ram #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_tags (
    .clk(clk), .we(wr_ok), .waddr(wr_idx), .wglobal(wr_global),
    .wasid(wr_asid), .wvpn(wr_vpn), .raddr(raddr),
    .rglobal(t_global), .rasid(t_asid), .rvpn(t_vpn)
  );

  tlbinv_valid_bits #(.ENTRIES(ENTRIES)) u_valid (
    .clk(clk), .rst(rst), .set_en(wr_ok), .set_idx(wr_idx), .set_val(wr_valid),
    .clr_en(busy && hit), .clr_idx(ptr), .cur_valid(cur_valid),
    .probe_idx(probe_idx), .probe_q(probe_valid)
  );

  tlbinv_matcher #(.ASID_W(ASID_W), .VPN_W(VPN_W)) u_match (
    .op(op_q), .ent_valid(cur_valid), .ent_global(t_global),
    .ent_asid(t_asid), .ent_vpn(t_vpn), .key_asid(asid_q), .key_vpn(vpn_q),
    .hit(hit)
  );

  assert_priv_no_walk_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_user) |=> (priv_exc && !busy && !illegal_op));
  assert_illegal_no_walk_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (!busy && !done && !flush_req));
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, priv_exc, illegal_op}));
  assert_hold_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(start)) |-> ($stable(op_q) && $stable(asid_q) && $stable(vpn_q)));

endmodule

// File: tb/test_tlbinv_engine.sv
`timescale 1ns/1ps
module test_tlbinv_engine;
  localparam int N = 16;
  localparam int AW = 10;
  localparam int VW = 19;
  localparam int IW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, cmd_user = 0;
  logic [4:0] cmd_op = 0;
  logic [AW-1:0] cmd_asid = 0;
  logic [VW-1:0] cmd_vpn = 0;
  logic wr_en = 0, wr_valid = 0, wr_global = 0;
  logic [IW-1:0] wr_idx = 0, probe_idx = 0;
  logic [AW-1:0] wr_asid = 0;
  logic [VW-1:0] wr_vpn = 0;
  logic probe_valid, busy, done, flush_req, priv_exc, illegal_op;

  int checks = 0, fails = 0;
  logic          ev [N];
  logic          eg [N];
  logic [AW-1:0] ea [N];
  logic [VW-1:0] ep [N];

  always #2.5 clk = ~clk;

  tlbinv_engine #(.ENTRIES(N), .ASID_W(AW), .VPN_W(VW)) i_tlbinv_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_asid(cmd_asid), .cmd_vpn(cmd_vpn), .cmd_user(cmd_user),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_global(wr_global),
    .wr_asid(wr_asid), .wr_vpn(wr_vpn), .probe_idx(probe_idx),
    .probe_valid(probe_valid), .busy(busy), .done(done), .flush_req(flush_req),
    .priv_exc(priv_exc), .illegal_op(illegal_op)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic model_hit(input int op, input int i,
                                     input logic [AW-1:0] a, input logic [VW-1:0] p);
    case (op)
      0, 1: return 1'b1;
      2: return eg[i];
      3: return !eg[i];
      4: return !eg[i] && ea[i] == a;
      5: return ep[i] == p && ea[i] == a;
      6: return ep[i] == p && (ea[i] == a || eg[i]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic write_entry(input int i, input logic v, input logic g,
                             input logic [AW-1:0] a, input logic [VW-1:0] p);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(i); wr_valid = v; wr_global = g; wr_asid = a; wr_vpn = p;
    @(negedge clk);
    wr_en = 0;
    ev[i] = v; eg[i] = g; ea[i] = a; ep[i] = p;
  endtask

  task automatic load_pattern();
    for (int i = 0; i < N; i++)
      write_entry(i, i != 15, (i % 4) == 0, AW'(10'h020 + i % 3),
                  (i % 2) ? VW'(19'h00AB0) : VW'(19'h00CD0));
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      probe_idx = IW'(i);
      @(negedge clk);
      check(req, {31'd0, probe_valid}, {31'd0, ev[i]});
    end
  endtask

  task automatic issue(input int op, input logic [AW-1:0] a, input logic [VW-1:0] p,
                       input logic user);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 5'(op); cmd_asid = a; cmd_vpn = p; cmd_user = user;
    @(negedge clk);
    cmd_valid = 0; cmd_user = 0;
  endtask

  task automatic run_legal(input string req, input int op,
                           input logic [AW-1:0] a, input logic [VW-1:0] p);
    int cnt = 0;
    load_pattern();
    issue(op, a, p, 1'b0);
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    check({req, " busy length (R11)"}, cnt, N);
    check({req, " done (R11)"}, {31'd0, done}, 1);
    check({req, " flush (R11)"}, {31'd0, flush_req}, 1);
    @(negedge clk);
    check({req, " done pulse (R11)"}, {31'd0, done}, 0);
    for (int i = 0; i < N; i++)
      if (model_hit(op, i, a, p)) ev[i] = 1'b0;
    check_all(req);
  endtask

  task automatic t_reset();
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 flush", {31'd0, flush_req}, 0);
    check("R1 priv", {31'd0, priv_exc}, 0);
    check("R1 illegal", {31'd0, illegal_op}, 0);
    for (int i = 0; i < N; i++) ev[i] = 1'b0;
    check_all("R1 valid after reset");
  endtask

  task automatic t_write();
    load_pattern();
    check_all("R2 write/probe");
    write_entry(3, 1'b0, 1'b0, 10'h020, 19'h00AB0);
    check_all("R2 write clears");
  endtask

  task automatic t_refused(input string req, input int op, input logic user);
    load_pattern();
    issue(op, 10'h020, 19'h00AB0, user);
    check({req, " priv"}, {31'd0, priv_exc}, {31'd0, user});
    check({req, " illegal"}, {31'd0, illegal_op}, {31'd0, !user});
    check({req, " busy"}, {31'd0, busy}, 0);
    @(negedge clk);
    check({req, " no done"}, {31'd0, done | flush_req}, 0);
    check({req, " pulse ends"}, {31'd0, priv_exc | illegal_op}, 0);
    check_all(req);
  endtask

  task automatic t_busy_ignore();
    load_pattern();
    issue(3, 10'h0, 19'h0, 1'b0);
    repeat (3) @(negedge clk);
    cmd_valid = 1; cmd_op = 5'd0;
    wr_en = 1; wr_idx = 4'd1; wr_valid = 1; wr_global = 0; wr_asid = 10'h020; wr_vpn = 0;
    @(negedge clk);
    cmd_valid = 0; wr_en = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R12 second cmd ignored", {31'd0, busy}, 0);
    for (int i = 0; i < N; i++)
      if (model_hit(3, i, 10'h0, 19'h0)) ev[i] = 1'b0;
    check_all("R12 write ignored while busy");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write();
    run_legal("R3 op0", 0, 10'h021, 19'h00AB0);
    run_legal("R3 op1", 1, 10'h000, 19'h00000);
    run_legal("R4 op2", 2, 10'h021, 19'h00AB0);
    run_legal("R5 op3", 3, 10'h021, 19'h00AB0);
    run_legal("R6 op4", 4, 10'h021, 19'h00AB0);
    run_legal("R7 op5", 5, 10'h022, 19'h00CD0);
    run_legal("R8 op6", 6, 10'h021, 19'h00AB0);
    t_refused("R9 op7", 7, 1'b0);
    t_refused("R9 op31", 31, 1'b0);
    t_refused("R10 user op0", 0, 1'b1);
    t_refused("R10 user op20", 20, 1'b1);
    t_busy_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule